// File: doc/BRIEF.md
# Transmit Packet Priority Arbiter

This block merges outgoing packets from several sources onto one byte stream headed for the physical layer. The sources are one link-packet source, one subnet-management source and a parameterised number of data lanes. Each source raises a ready flag while it holds a complete packet. It presents the current byte of that packet and advances to the next byte when the arbiter pulses its pop strobe.

When the stream is free, the arbiter picks one source. It sends a start delimiter, then the packet bytes, then an end delimiter. Each output symbol carries a 2-bit kind code beside the byte. The arbiter finds the end of a packet by counting the bytes it has sent. A link packet has a fixed size. For the other sources, the size comes from a length field that the arbiter reads from the header while the header streams past. A downstream ready input may pause the stream at any symbol.

Top module: `tx_pkt_arbiter`

## Requirements
- R1: After reset, and at any time no source is ready while the arbiter is idle, `out_kind` is 00 (idle) and no pop strobe is asserted.
- R2: The kind codes are 00 idle, 01 start delimiter, 10 data byte and 11 end delimiter. Every packet is sent as exactly one 01, then its data bytes, then one 11.
- R3: When several kinds of source are ready at a selection point, the link source wins over the management source, and the management source wins over every data lane.
- R4: Among ready data lanes, the arbiter serves the first one found at or after a rotating pointer, wrapping around. The pointer is lane 0 after reset. It moves to the lane after the one served only when that lane's end delimiter is accepted.
- R5: A link packet is exactly LINK_LEN (6) data bytes long.
- R6: A management or data packet carries an 11-bit length in 4-byte words. Bits [2:0] of header byte index 2 hold length bits [10:8], and header byte index 3 holds length bits [7:0]. The packet is sent as length×4 data bytes (length ≥ 1).
- R7: A source is chosen only while idle. A higher-priority source that becomes ready in mid-packet waits until the current packet ends.
- R8: While `out_rdy` is low, no pop is issued, the byte count does not advance, and `out_kind`/`out_byte` hold their values.
- R9: Each data byte accepted (`out_kind`=10 with `out_rdy` high) equals the chosen source's current byte. It pops that source and no other, and no pop occurs on any other symbol.
- R10: After an end delimiter is accepted, the next symbol is idle, and any new start delimiter follows one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_rdy | input | 1 | Link source holds a packet |
| link_byte | input | 8 | Link source current byte |
| link_pop | output | 1 | Link source byte consumed |
| mgmt_rdy | input | 1 | Management source holds a packet |
| mgmt_byte | input | 8 | Management source current byte |
| mgmt_pop | output | 1 | Management source byte consumed |
| data_rdy | input | N_DATA | Per-lane packet pending |
| data_byte | input | 8*N_DATA | Per-lane current byte, lane i at bits [8i+7:8i] |
| data_pop | output | N_DATA | Per-lane byte consumed |
| out_rdy | input | 1 | Downstream accepts the current symbol |
| out_kind | output | 2 | Symbol kind: 00 idle, 01 start, 10 data, 11 end |
| out_byte | output | 8 | Data byte, zero on non-data symbols |

## Verification
The assertions rely on three things about the sources. A source that raises ready already holds a whole packet. It keeps its current byte steady until popped. It drops ready only after its last byte has been popped. The assertions also rely on every management or data header carrying a nonzero length. The bench source models produce packets only from a counter of issued packets, with a length field fixed while a packet is pending. Lengths are chosen in the range 1 to 2047 words, so stimulus never breaks these assumptions, even under the pseudo-random downstream stalls.

// File: rtl/tx_arb_pkg.sv
package tx_arb_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        K_IDLE = 2'b00,
        K_SOP  = 2'b01,
        K_DATA = 2'b10,
        K_EOP  = 2'b11
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SOP  = 2'd1,
        ST_BODY = 2'd2,
        ST_EOP  = 2'd3
    } state_e;

    typedef enum logic [1:0] {
        SRC_LINK = 2'd0,
        SRC_MGMT = 2'd1,
        SRC_DATA = 2'd2
    } src_e;
endpackage

// File: rtl/tx_arb_rr_pick.sv
module tx_arb_rr_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            int c;
            c = int'(ptr) + i;
            if (c >= N) c = c - N;
            if (!any && req[c]) begin
                any = 1'b1;
                idx = IW'(c);
            end
        end
    end
endmodule

// File: rtl/tx_arb_src_mux.sv
module tx_arb_src_mux
    import tx_arb_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  src_e                 sel_src,
    input  logic [IW-1:0]        sel_lane,
    input  logic                 go,
    input  logic [BYTE_W-1:0]    link_byte,
    input  logic [BYTE_W-1:0]    mgmt_byte,
    input  logic [N*BYTE_W-1:0]  data_byte,
    output logic [BYTE_W-1:0]    cur_byte,
    output logic                 link_pop,
    output logic                 mgmt_pop,
    output logic [N-1:0]         data_pop
);
    always_comb begin
        case (sel_src)
            SRC_LINK: cur_byte = link_byte;
            SRC_MGMT: cur_byte = mgmt_byte;
            default:  cur_byte = data_byte[int'(sel_lane)*BYTE_W +: BYTE_W];
        endcase
        link_pop = go && (sel_src == SRC_LINK);
        mgmt_pop = go && (sel_src == SRC_MGMT);
        data_pop = '0;
        if (go && sel_src == SRC_DATA) data_pop[sel_lane] = 1'b1;
    end
endmodule

// File: rtl/tx_pkt_arbiter.sv
module tx_pkt_arbiter
    import tx_arb_pkg::*;
#(
    parameter int N_DATA   = 4,
    parameter int LEN_W    = 11,
    parameter int LINK_LEN = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     link_rdy,
    input  logic [7:0]               link_byte,
    output logic                     link_pop,
    input  logic                     mgmt_rdy,
    input  logic [7:0]               mgmt_byte,
    output logic                     mgmt_pop,
    input  logic [N_DATA-1:0]        data_rdy,
    input  logic [N_DATA*8-1:0]      data_byte,
    output logic [N_DATA-1:0]        data_pop,
    input  logic                     out_rdy,
    output logic [1:0]               out_kind,
    output logic [7:0]               out_byte
);
    localparam int IW   = (N_DATA > 1) ? $clog2(N_DATA) : 1;
    localparam int CW   = LEN_W + 2;
    localparam int HI_W = LEN_W - BYTE_W;

    typedef struct packed {
        state_e            st;
        src_e              src;
        logic [IW-1:0]     lane;
        logic [IW-1:0]     ptr;
        logic [CW-1:0]     cnt;
        logic [LEN_W-1:0]  len;
    } regs_t;

    regs_t r_q, r_d;

    logic              pick_any;
    logic [IW-1:0]     pick_idx;
    logic [BYTE_W-1:0] cur_byte;
    logic              go;
    logic [LEN_W-1:0]  eff_len;
    logic [CW-1:0]     lim;
    logic              end_now;

    tx_arb_rr_pick #(.N(N_DATA), .IW(IW)) u_pick (
        .req (data_rdy),
        .ptr (r_q.ptr),
        .any (pick_any),
        .idx (pick_idx)
    );

    assign go = (r_q.st == ST_BODY) && out_rdy;

    tx_arb_src_mux #(.N(N_DATA), .IW(IW)) u_mux (
        .sel_src   (r_q.src),
        .sel_lane  (r_q.lane),
        .go        (go),
        .link_byte (link_byte),
        .mgmt_byte (mgmt_byte),
        .data_byte (data_byte),
        .cur_byte  (cur_byte),
        .link_pop  (link_pop),
        .mgmt_pop  (mgmt_pop),
        .data_pop  (data_pop)
    );

    // Length becomes complete while header byte 3 is on the output.
    always_comb begin
        eff_len = r_q.len;
        if (r_q.cnt == CW'(3)) eff_len = {r_q.len[LEN_W-1:BYTE_W], cur_byte};
        lim = {eff_len, 2'b00};
        if (r_q.src == SRC_LINK)
            end_now = (r_q.cnt == CW'(LINK_LEN - 1));
        else
            end_now = (r_q.cnt >= CW'(3)) && ((r_q.cnt + CW'(1)) == lim);
    end

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (link_rdy) begin
                    r_d.src = SRC_LINK;
                    r_d.st  = ST_SOP;
                end else if (mgmt_rdy) begin
                    r_d.src = SRC_MGMT;
                    r_d.st  = ST_SOP;
                end else if (pick_any) begin
                    r_d.src  = SRC_DATA;
                    r_d.lane = pick_idx;
                    r_d.st   = ST_SOP;
                end
            end
            ST_SOP: begin
                if (out_rdy) begin
                    r_d.st  = ST_BODY;
                    r_d.cnt = '0;
                    r_d.len = '0;
                end
            end
            ST_BODY: begin
                if (out_rdy) begin
                    r_d.cnt = r_q.cnt + CW'(1);
                    if (r_q.cnt == CW'(2))
                        r_d.len[LEN_W-1:BYTE_W] = cur_byte[HI_W-1:0];
                    if (r_q.cnt == CW'(3))
                        r_d.len[BYTE_W-1:0] = cur_byte;
                    if (end_now) r_d.st = ST_EOP;
                end
            end
            default: begin
                if (out_rdy) begin
                    r_d.st = ST_IDLE;
                    if (r_q.src == SRC_DATA)
                        r_d.ptr = (r_q.lane == IW'(N_DATA - 1)) ? '0 : r_q.lane + IW'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (r_q.st)
            ST_SOP:  out_kind = K_SOP;
            ST_BODY: out_kind = K_DATA;
            ST_EOP:  out_kind = K_EOP;
            default: out_kind = K_IDLE;
        endcase
        out_byte = (r_q.st == ST_BODY) ? cur_byte : '0;
    end
endmodule

// File: rtl/tx_arb_chk.sv
module tx_arb_chk #(
    parameter int N_DATA   = 4,
    parameter int LINK_LEN = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              link_rdy,
    input logic              link_pop,
    input logic              mgmt_rdy,
    input logic              mgmt_pop,
    input logic [N_DATA-1:0] data_rdy,
    input logic [N_DATA-1:0] data_pop,
    input logic              out_rdy,
    input logic [1:0]        out_kind
);
    logic [N_DATA+1:0] pops;
    logic [7:0]        lk_cnt;

    assign pops = {data_pop, mgmt_pop, link_pop};

    always_ff @(posedge clk) begin
        if (!rst_n)                lk_cnt <= '0;
        else if (out_kind == 2'b01) lk_cnt <= '0;
        else if (link_pop)         lk_cnt <= lk_cnt + 8'd1;
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_kind == 2'b00 && !link_rdy && !mgmt_rdy && data_rdy == '0) |=> out_kind == 2'b00);

    assert_sop_then_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_kind == 2'b01 && out_rdy) |=> out_kind == 2'b10);

    assert_link_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        link_pop |-> lk_cnt < 8'(LINK_LEN));

    assert_no_pop_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_rdy |-> pops == '0);

    assert_hold_kind_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_rdy && out_kind != 2'b00) |=> $stable(out_kind));

    assert_single_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pops) <= 1);

    assert_pop_on_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pops != '0) |-> (out_kind == 2'b10 && out_rdy));

    assert_gap_after_eop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_kind == 2'b11 && out_rdy) |=> out_kind == 2'b00);
endmodule

bind tx_pkt_arbiter tx_arb_chk #(.N_DATA(N_DATA), .LINK_LEN(LINK_LEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .link_rdy (link_rdy),
    .link_pop (link_pop),
    .mgmt_rdy (mgmt_rdy),
    .mgmt_pop (mgmt_pop),
    .data_rdy (data_rdy),
    .data_pop (data_pop),
    .out_rdy  (out_rdy),
    .out_kind (out_kind)
);

// File: tb/tb_tx_pkt_arbiter.sv
module tb_tx_pkt_arbiter;
    localparam int ND = 3;
    localparam int NS = ND + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic              link_rdy, mgmt_rdy, link_pop, mgmt_pop;
    logic [7:0]        link_byte, mgmt_byte;
    logic [ND-1:0]     data_rdy, data_pop;
    logic [ND*8-1:0]   data_byte;
    logic              out_rdy = 1'b1;
    logic [1:0]        out_kind;
    logic [7:0]        out_byte;

    tx_pkt_arbiter #(.N_DATA(ND), .LEN_W(11), .LINK_LEN(6)) dut (
        .clk(clk), .rst_n(rst_n),
        .link_rdy(link_rdy), .link_byte(link_byte), .link_pop(link_pop),
        .mgmt_rdy(mgmt_rdy), .mgmt_byte(mgmt_byte), .mgmt_pop(mgmt_pop),
        .data_rdy(data_rdy), .data_byte(data_byte), .data_pop(data_pop),
        .out_rdy(out_rdy), .out_kind(out_kind), .out_byte(out_byte)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Source ids: 0 link, 1 management, 2+i data lane i.
    function automatic logic [7:0] byte_of(int s, int i, logic [10:0] lw, logic [3:0] tg);
        case (i)
            0:       byte_of = {4'(s), tg};
            1:       byte_of = ~{tg, 4'(s)};
            2:       byte_of = {5'b10110, lw[10:8]};
            3:       byte_of = lw[7:0];
            default: byte_of = 8'(i * 37 + s * 11);
        endcase
    endfunction

    int          issued [NS];
    int          done_c [NS];
    int          idx    [NS];
    logic [10:0] lenw   [NS];
    logic [3:0]  tag    [NS];
    logic [NS-1:0] rdy_v, pop_v;
    bit stall_en = 0;
    logic [15:0] lfsr = 16'hACE1;

    function automatic int total(int s);
        total = (s == 0) ? 6 : int'(lenw[s]) * 4;
    endfunction

    always_comb begin
        for (int s = 0; s < NS; s++) rdy_v[s] = (issued[s] != done_c[s]);
    end
    assign link_rdy = rdy_v[0];
    assign mgmt_rdy = rdy_v[1];
    assign data_rdy = rdy_v[NS-1:2];
    assign pop_v    = {data_pop, mgmt_pop, link_pop};

    always_comb begin
        link_byte = byte_of(0, idx[0], lenw[0], tag[0]);
        mgmt_byte = byte_of(1, idx[1], lenw[1], tag[1]);
        for (int l = 0; l < ND; l++)
            data_byte[l*8 +: 8] = byte_of(l + 2, idx[l+2], lenw[l+2], tag[l+2]);
    end

    always @(posedge clk) begin
        for (int s = 0; s < NS; s++) begin
            if (!rst_n) begin
                done_c[s] <= 0;
                idx[s]    <= 0;
            end else if (pop_v[s]) begin
                if (idx[s] + 1 == total(s)) begin
                    idx[s]    <= 0;
                    done_c[s] <= done_c[s] + 1;
                end else begin
                    idx[s] <= idx[s] + 1;
                end
            end
        end
        lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_rdy <= !stall_en || lfsr[0] || lfsr[3];
    end

    // Output monitor
    bit   in_pkt = 0, prev_stall = 0, prev_eop = 0;
    int   m_src = 0, m_cnt = 0;
    logic [1:0] prev_kind = 2'b00;
    logic [7:0] prev_byte = 8'h00;
    int   log_src [512];
    int   log_n = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_eop) chk(out_kind == 2'b00, "R10", out_kind, 0);
            prev_eop = out_rdy && out_kind == 2'b11;
            if (prev_stall) begin
                chk(out_kind == prev_kind, "R8 kind hold", out_kind, prev_kind);
                chk(out_byte == prev_byte, "R8 byte hold", out_byte, prev_byte);
            end
            prev_stall = !out_rdy && out_kind != 2'b00;
            prev_kind  = out_kind;
            prev_byte  = out_byte;
            if (!out_rdy && out_kind != 2'b00) chk(pop_v == '0, "R8 pop", pop_v, 0);
            if (out_kind != 2'b10 && pop_v != '0) chk(1'b0, "R9 stray pop", pop_v, 0);
            if (out_rdy) begin
                case (out_kind)
                    2'b01: begin
                        chk(!in_pkt, "R2 start", in_pkt, 0);
                        in_pkt = 1;
                        m_cnt  = 0;
                    end
                    2'b10: begin
                        chk(in_pkt, "R2 data outside packet", in_pkt, 1);
                        if (m_cnt == 0) begin
                            m_src = int'(out_byte[7:4]);
                            if (m_src >= NS) begin
                                chk(1'b0, "R9 source id", m_src, 0);
                                m_src = 0;
                            end
                        end
                        chk(out_byte == byte_of(m_src, m_cnt, lenw[m_src], tag[m_src]), "R9 byte",
                            out_byte, byte_of(m_src, m_cnt, lenw[m_src], tag[m_src]));
                        chk(pop_v == NS'(1 << m_src), "R9 pop target", pop_v, 1 << m_src);
                        m_cnt++;
                    end
                    2'b11: begin
                        chk(in_pkt, "R2 end", in_pkt, 1);
                        chk(m_cnt == total(m_src), (m_src == 0) ? "R5 length" : "R6 length",
                            m_cnt, total(m_src));
                        if (log_n < 512) log_src[log_n] = m_src;
                        log_n++;
                        in_pkt = 0;
                    end
                    default: ;
                endcase
            end
        end
    end

    int base = 0;
    int ep = 0;

    task automatic issue(int s, int lw);
        lenw[s] = 11'(lw);
        tag[s]  = tag[s] + 4'd1;
        issued[s]++;
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic settle();
        int g = 0;
        bit busy = 1;
        while (busy && g < 30000) begin
            step();
            g++;
            busy = (out_kind != 2'b00) || in_pkt;
            for (int s = 0; s < NS; s++) if (issued[s] != done_c[s]) busy = 1;
        end
        repeat (2) step();
    endtask

    task automatic exp_src(int k, int s, string req);
        chk(log_src[base + k] == s, req, log_src[base + k], s);
    endtask

    task automatic served_lane(int l);
        ep = (l + 1) % ND;
    endtask

    initial begin
        for (int s = 0; s < NS; s++) begin
            issued[s] = 0;
            lenw[s]   = 11'd1;
            tag[s]    = 4'd0;
        end
        repeat (4) @(posedge clk);
        rst_n = 1'b1;

        // R1: reset state, nothing pending
        repeat (3) begin
            step();
            chk(out_kind == 2'b00, "R1 idle kind", out_kind, 0);
            chk(pop_v == '0, "R1 no pop", pop_v, 0);
        end

        // R5, R2: lone link packet
        base = log_n;
        step(); issue(0, 1); settle();
        chk(log_n - base == 1, "R5 packet count", log_n - base, 1);
        exp_src(0, 0, "R5 source");

        // R6: management length sweep, including the widest length field
        for (int lw = 1; lw <= 12; lw++) begin
            base = log_n;
            step(); issue(1, lw); settle();
            exp_src(0, 1, "R6 mgmt source");
        end
        base = log_n;
        step(); issue(1, 291); settle();
        exp_src(0, 1, "R6 mgmt 291 words");
        step(); issue(1, 2047); settle();
        exp_src(1, 1, "R6 mgmt 2047 words");

        // R6, R8: every lane, lengths 1..6, under downstream stalls
        stall_en = 1;
        for (int l = 0; l < ND; l++) begin
            for (int lw = 1; lw <= 6; lw++) begin
                base = log_n;
                step(); issue(l + 2, lw); settle();
                exp_src(0, l + 2, "R6 lane source");
                served_lane(l);
            end
        end
        stall_en = 0;

        // R3, R4: every source ready together
        base = log_n;
        step();
        for (int s = 0; s < NS; s++) issue(s, 2);
        settle();
        chk(log_n - base == NS, "R3 count", log_n - base, NS);
        exp_src(0, 0, "R3 link first");
        exp_src(1, 1, "R3 mgmt second");
        for (int k = 0; k < ND; k++) exp_src(2 + k, 2 + (ep + k) % ND, "R4 lane order");
        served_lane((ep + ND - 1) % ND);

        // R4: rotation with partial request sets
        base = log_n;
        step(); issue(2, 1); issue(4, 1); settle();
        exp_src(0, (ep <= 0) ? 2 : 4, "R4 two lanes first");
        exp_src(1, (ep <= 0) ? 4 : 2, "R4 two lanes second");
        served_lane(log_src[base + 1] - 2);
        base = log_n;
        step(); issue(3, 1); settle();
        exp_src(0, 3, "R4 single lane");
        served_lane(1);
        base = log_n;
        step(); issue(2, 1); issue(3, 1); issue(4, 1); settle();
        for (int k = 0; k < ND; k++) exp_src(k, 2 + (ep + k) % ND, "R4 three lanes");
        served_lane((ep + ND - 1) % ND);
        base = log_n;
        step(); issue(2, 1); issue(3, 1); settle();
        exp_src(0, 2, "R4 wrap to lane 0");
        exp_src(1, 3, "R4 then lane 1");
        served_lane(1);

        // R7: link and mgmt arrive mid-packet, no preemption
        base = log_n;
        step(); issue(2, 8);
        while (!(in_pkt && m_cnt >= 3)) step();
        issue(0, 1); issue(1, 1);
        settle();
        exp_src(0, 2, "R7 lane completes first");
        exp_src(1, 0, "R7 link after");
        exp_src(2, 1, "R7 mgmt last");
        served_lane(0);

        // R3, R4, R8: repeated full rounds under stalls
        stall_en = 1;
        for (int r = 0; r < 4; r++) begin
            base = log_n;
            step();
            for (int s = 0; s < NS; s++) issue(s, r + 1);
            settle();
            exp_src(0, 0, "R3 round link");
            exp_src(1, 1, "R3 round mgmt");
            for (int k = 0; k < ND; k++) exp_src(2 + k, 2 + (ep + k) % ND, "R4 round lane");
            served_lane((ep + ND - 1) % ND);
        end
        stall_en = 0;

        // R1: quiet again after all traffic
        step();
        chk(out_kind == 2'b00, "R1 final idle", out_kind, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule